// File: doc/BRIEF.md
# Display Raster Timing and Position Counters

This block produces the raster timing for one display pipe and keeps the position and event counters that software reads back to tell where the scan-out is. It counts pixel clocks across a programmable line and lines across a programmable frame. From those counts it drives a data-enable, horizontal and vertical blank, and horizontal and vertical sync. It raises single-cycle pulses for start of vertical blank, frame start and start of vertical sync. The start-of-vblank pulse also acts as the load strobe for double-buffered configuration elsewhere in the pipe.

Vertical events take effect at the leading edge of horizontal sync on the line before the programmed line number, not at the start of a line. The scanline counter follows the same rule, so it lags the raster by part of a line. The block also keeps a pixel counter, a frame counter, a free-running timestamp and a per-frame timestamp captured at start of vblank. A small register port reads all of these. Counters wider than the data word are read as a low and a high word; reading the low word freezes the matching high word. The port also offers sticky event status bits that a write of 1 clears.

Top module: `scan_position_unit`

## Requirements
- R1: The pixel position runs 0..htotal-1 and the line 0..vtotal-1. One cycle after each position, de_o is high when pixel < hactive and line < vblank_start, hblank_o is high when pixel >= hactive, and hsync_o is high when hsync_start <= pixel < hsync_end.
- R2: In the cycle after pixel hsync_start of line vblank_start-1, evt_vblank_o and latch_o pulse for one cycle and vblank_o rises. vblank_o falls in the cycle after pixel hsync_start of line vtotal-1.
- R3: In the cycle after pixel hsync_start of line vsync_start-1, evt_vsync_o pulses and vsync_o rises. vsync_o falls in the cycle after pixel hsync_start of line vsync_end-1.
- R4: evt_frame_o pulses in the cycle after pixel hactive (the start of horizontal blank) of line vblank_start+cfg_fs_delay. That is 1 to 4 lines after start of vblank for a delay field of 0 to 3.
- R5: The scanline counter takes the current line number at each pixel hsync_start, so it reads vtotal-1 across the active part of line 0 and vblank_start-1 just after vblank begins. It is 0 after reset until the first hsync edge.
- R6: The pixel counter is 0 at pixel 0 of line 0, rises by 1 every clock, and returns to 0 after the last pixel of the frame (vblank_start*htotal clocks after pixel 0 of line 0 it reads that product).
- R7: The frame counter rises by 1 at each start of vblank and wraps modulo 2^FCW (FCW is 24 by default).
- R8: The current timestamp is 0 after reset and rises by 1 every clock. At each start of vblank, the frame timestamp takes the current timestamp value held before that edge.
- R9: A read with rd_en updates rd_data on the next clock; otherwise rd_data holds. Addresses: 0 scanline; 1/2 pixel counter low/high; 3/4 frame counter low/high; 5/6 current timestamp low/high; 7/8 frame timestamp low/high; 9 status. Any other address reads 0.
- R10: Reading a low word stores that counter's high word in the same cycle. A later read of the high word returns the stored value, whatever the live counter has become.
- R11: Status bit 0 is start-of-vblank, bit 1 frame start, bit 2 start-of-vsync. Each is set by its event and cleared by a write of 1 to that bit at address 9. A set in the same cycle wins over the clear. Writes to any other address change nothing.
- R12: The timing inputs (totals, hactive, sync positions, vblank start and frame-start delay) are taken in only during reset and at the start-of-vblank strobe. Changes at other times have no effect until the next strobe.
- R13: During and after reset all counters, status bits, rd_data and every timing and event output are 0, and the raster restarts at line 0, pixel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_htotal | input | HW | Clocks per line |
| cfg_hactive | input | HW | Visible pixels per line; start of horizontal blank |
| cfg_hsync_start | input | HW | Pixel at which horizontal sync begins |
| cfg_hsync_end | input | HW | Pixel at which horizontal sync ends |
| cfg_vtotal | input | VW | Lines per frame |
| cfg_vblank_start | input | VW | First line of vertical blank |
| cfg_vsync_start | input | VW | First line of vertical sync |
| cfg_vsync_end | input | VW | Line at which vertical sync ends |
| cfg_fs_delay | input | 2 | Extra lines of delay before frame start |
| de_o | output | 1 | Data enable (visible pixel) |
| hblank_o | output | 1 | Horizontal blank |
| hsync_o | output | 1 | Horizontal sync |
| vblank_o | output | 1 | Vertical blank |
| vsync_o | output | 1 | Vertical sync |
| latch_o | output | 1 | Load strobe for double-buffered registers |
| evt_vblank_o | output | 1 | Start-of-vblank pulse |
| evt_frame_o | output | 1 | Frame-start pulse |
| evt_vsync_o | output | 1 | Start-of-vsync pulse |
| rd_en | input | 1 | Read request |
| rd_addr | input | 4 | Read address |
| rd_data | output | DW | Read data, one cycle after the request |
| wr_en | input | 1 | Write request |
| wr_addr | input | 4 | Write address (only 9 has an effect) |
| wr_data | input | 3 | Write-1-to-clear mask for the status bits |

## Verification
The bench goes after the hsync-edge placement of vertical events: a design that fired them at the start of the line would pulse start of vblank and move the scanline counter too early. That shows up as the wrong scanline value on line 0 and vblank_o out of step with hsync_o. It sweeps the frame-start delay through all four values, where an off-by-one would put frame start on the wrong line. It also changes the timing inputs in mid-frame, where a design that used them at once would break that frame's line length. Finally it lets the low word of the timestamp go stale long enough for the high word to move, so a high read without a snapshot returns a newer value. It drives enough frames to wrap a narrow frame counter, and it times status clears against fresh events.

// File: rtl/spu_pkg.sv
package spu_pkg;

    // Event set; member order gives the status bit positions (LSB last).
    typedef struct packed {
        logic vsync_start;
        logic frame_start;
        logic vbl_start;
    } spu_evt_t;

    localparam int SPU_AW     = 4;
    localparam int SPU_NEVT   = 3;
    localparam int SPU_NSPLIT = 4;   // pixel, frame, timestamp now, timestamp at vblank

    localparam logic [SPU_AW-1:0] RA_SCAN = SPU_AW'(0);
    localparam logic [SPU_AW-1:0] RA_STAT = SPU_AW'(9);

    function automatic logic [SPU_AW-1:0] ra_lo(input int k);
        return SPU_AW'(1 + 2 * k);
    endfunction

    function automatic logic [SPU_AW-1:0] ra_hi(input int k);
        return SPU_AW'(2 + 2 * k);
    endfunction

endpackage

// File: rtl/spu_raster.sv
module spu_raster
    import spu_pkg::*;
#(
    parameter int HW  = 12,
    parameter int VW  = 12,
    parameter int PCW = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [HW-1:0]  htotal,
    input  logic [HW-1:0]  hactive,
    input  logic [HW-1:0]  hs_start,
    input  logic [HW-1:0]  hs_end,
    input  logic [VW-1:0]  vtotal,
    input  logic [VW-1:0]  vb_start,
    input  logic [VW-1:0]  vs_start,
    input  logic [VW-1:0]  vs_end,
    input  logic [1:0]     fs_delay,
    output logic [VW-1:0]  line_q,
    output logic           hs_edge,
    output spu_evt_t       evt_now,
    output spu_evt_t       evt_q,
    output logic [PCW-1:0] pix_q,
    output logic           de_o,
    output logic           hblank_o,
    output logic           hsync_o,
    output logic           vblank_o,
    output logic           vsync_o
);
    localparam logic [HW-1:0]  HONE = HW'(1);
    localparam logic [VW-1:0]  VONE = VW'(1);
    localparam logic [PCW-1:0] PONE = PCW'(1);

    logic [HW-1:0] col_q;
    logic          h_last;
    logic          v_last;
    logic          vs_off;
    logic          vb_off;
    logic [VW:0]   fs_line;

    always_comb begin
        h_last  = col_q >= (htotal - HONE);
        v_last  = line_q >= (vtotal - VONE);
        hs_edge = col_q == hs_start;
        fs_line = {1'b0, vb_start} + {{(VW-1){1'b0}}, fs_delay};
        evt_now.vbl_start   = hs_edge && (line_q == (vb_start - VONE));
        evt_now.vsync_start = hs_edge && (line_q == (vs_start - VONE));
        evt_now.frame_start = (col_q == hactive) && ({1'b0, line_q} == fs_line);
        vs_off  = hs_edge && (line_q == (vs_end - VONE));
        vb_off  = hs_edge && (line_q == (vtotal - VONE));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            col_q    <= '0;
            line_q   <= '0;
            pix_q    <= '0;
            evt_q    <= '0;
            de_o     <= 1'b0;
            hblank_o <= 1'b0;
            hsync_o  <= 1'b0;
            vblank_o <= 1'b0;
            vsync_o  <= 1'b0;
        end else begin
            if (h_last) begin
                col_q  <= '0;
                line_q <= v_last ? '0 : line_q + VONE;
            end else begin
                col_q  <= col_q + HONE;
            end
            pix_q    <= (h_last && v_last) ? '0 : pix_q + PONE;
            evt_q    <= evt_now;
            de_o     <= (col_q < hactive) && (line_q < vb_start);
            hblank_o <= col_q >= hactive;
            hsync_o  <= (col_q >= hs_start) && (col_q < hs_end);
            if (evt_now.vbl_start)        vblank_o <= 1'b1;
            else if (vb_off)              vblank_o <= 1'b0;
            if (evt_now.vsync_start)      vsync_o  <= 1'b1;
            else if (vs_off)              vsync_o  <= 1'b0;
        end
    end

    // R2: start of vblank lands on the hsync leading edge
    p_vbl_on_hsync_r2: assert property (@(posedge clk) disable iff (rst)
        evt_q.vbl_start |-> (hsync_o && !$past(hsync_o)));

    // R2: the start-of-vblank pulse lasts one cycle
    p_vbl_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        evt_q.vbl_start |=> !evt_q.vbl_start);

    // R2: vertical blank only begins with the start-of-vblank event
    p_vblank_rise_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(vblank_o) |-> evt_q.vbl_start);

    // R3: vertical sync only begins with the start-of-vsync event
    p_vsync_rise_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(vsync_o) |-> evt_q.vsync_start);

    // R4: frame start lands on the start of horizontal blank
    p_fs_on_hblank_r4: assert property (@(posedge clk) disable iff (rst)
        evt_q.frame_start |-> (hblank_o && !$past(hblank_o)));

endmodule

// File: rtl/spu_stamp.sv
module spu_stamp #(
    parameter int VW  = 12,
    parameter int FCW = 24,
    parameter int TSW = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           hs_edge,
    input  logic [VW-1:0]  line_q,
    input  logic           vbl_start,
    output logic [VW-1:0]  scan_q,
    output logic [FCW-1:0] frame_q,
    output logic [TSW-1:0] tsn_q,
    output logic [TSW-1:0] tsf_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            scan_q  <= '0;
            frame_q <= '0;
            tsn_q   <= '0;
            tsf_q   <= '0;
        end else begin
            if (hs_edge)   scan_q <= line_q;
            if (vbl_start) tsf_q  <= tsn_q;
            frame_q <= frame_q + FCW'(vbl_start);
            tsn_q   <= tsn_q + TSW'(1);
        end
    end
endmodule

// File: rtl/spu_regs.sv
module spu_regs
    import spu_pkg::*;
#(
    parameter int DW  = 16,
    parameter int VW  = 12,
    parameter int PCW = 32,
    parameter int FCW = 24,
    parameter int TSW = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rd_en,
    input  logic [SPU_AW-1:0]   rd_addr,
    input  logic                wr_en,
    input  logic [SPU_AW-1:0]   wr_addr,
    input  logic [SPU_NEVT-1:0] wr_data,
    input  logic [VW-1:0]       scan,
    input  logic [PCW-1:0]      pix,
    input  logic [FCW-1:0]      frame,
    input  logic [TSW-1:0]      tsn,
    input  logic [TSW-1:0]      tsf,
    input  spu_evt_t            evt_now,
    output logic [DW-1:0]       rd_data
);
    localparam int WW = 2 * DW;

    logic [WW-1:0]                  wide [SPU_NSPLIT];
    logic [SPU_NSPLIT-1:0][DW-1:0]  contrib;
    logic [SPU_NEVT-1:0]            stat_q;
    logic [SPU_NEVT-1:0]            clr;
    logic [DW-1:0]                  rd_next;

    assign wide[0] = WW'(pix);
    assign wide[1] = WW'(frame);
    assign wide[2] = WW'(tsn);
    assign wide[3] = WW'(tsf);

    for (genvar k = 0; k < SPU_NSPLIT; k++) begin : g_split
        logic [DW-1:0] snap_q;
        logic          lo_hit;
        logic          hi_hit;

        assign lo_hit = rd_addr == ra_lo(k);
        assign hi_hit = rd_addr == ra_hi(k);
        assign contrib[k] = lo_hit ? wide[k][DW-1:0] : (hi_hit ? snap_q : '0);

        always_ff @(posedge clk) begin
            if (rst)                  snap_q <= '0;
            else if (rd_en && lo_hit) snap_q <= wide[k][WW-1:DW];
        end
    end

    always_comb begin
        rd_next = '0;
        if (rd_addr == RA_SCAN) rd_next = DW'(scan);
        if (rd_addr == RA_STAT) rd_next = DW'(stat_q);
        for (int k = 0; k < SPU_NSPLIT; k++) rd_next = rd_next | contrib[k];
        clr = (wr_en && (wr_addr == RA_STAT)) ? wr_data : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
            stat_q  <= '0;
        end else begin
            if (rd_en) rd_data <= rd_next;
            stat_q <= (stat_q & ~clr) | evt_now;
        end
    end

    // R11: an event always leaves its status bit set
    p_sticky_set_r11: assert property (@(posedge clk) disable iff (rst)
        $past(evt_now.vbl_start) |-> stat_q[0]);

    // R11: a clear without a competing event empties the bit
    p_sticky_clr_r11: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en && (wr_addr == RA_STAT) && wr_data[0] && !evt_now.vbl_start)
        |-> !stat_q[0]);

endmodule

// File: rtl/scan_position_unit.sv
module scan_position_unit
    import spu_pkg::*;
#(
    parameter int HW  = 12,
    parameter int VW  = 12,
    parameter int DW  = 16,
    parameter int PCW = 32,
    parameter int FCW = 24,
    parameter int TSW = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [HW-1:0]       cfg_htotal,
    input  logic [HW-1:0]       cfg_hactive,
    input  logic [HW-1:0]       cfg_hsync_start,
    input  logic [HW-1:0]       cfg_hsync_end,
    input  logic [VW-1:0]       cfg_vtotal,
    input  logic [VW-1:0]       cfg_vblank_start,
    input  logic [VW-1:0]       cfg_vsync_start,
    input  logic [VW-1:0]       cfg_vsync_end,
    input  logic [1:0]          cfg_fs_delay,
    output logic                de_o,
    output logic                hblank_o,
    output logic                hsync_o,
    output logic                vblank_o,
    output logic                vsync_o,
    output logic                latch_o,
    output logic                evt_vblank_o,
    output logic                evt_frame_o,
    output logic                evt_vsync_o,
    input  logic                rd_en,
    input  logic [SPU_AW-1:0]   rd_addr,
    output logic [DW-1:0]       rd_data,
    input  logic                wr_en,
    input  logic [SPU_AW-1:0]   wr_addr,
    input  logic [SPU_NEVT-1:0] wr_data
);
    logic [HW-1:0]  sh_htotal, sh_hactive, sh_hs_start, sh_hs_end;
    logic [VW-1:0]  sh_vtotal, sh_vb_start, sh_vs_start, sh_vs_end;
    logic [1:0]     sh_fs_delay;

    logic [VW-1:0]  line_q;
    logic           hs_edge;
    spu_evt_t       evt_now;
    spu_evt_t       evt_q;
    logic [PCW-1:0] pix_q;
    logic [VW-1:0]  scan_q;
    logic [FCW-1:0] frame_q;
    logic [TSW-1:0] tsn_q;
    logic [TSW-1:0] tsf_q;

    // Working copy of the timing, refreshed at reset and at the vblank strobe.
    always_ff @(posedge clk) begin
        if (rst || evt_now.vbl_start) begin
            sh_htotal   <= cfg_htotal;
            sh_hactive  <= cfg_hactive;
            sh_hs_start <= cfg_hsync_start;
            sh_hs_end   <= cfg_hsync_end;
            sh_vtotal   <= cfg_vtotal;
            sh_vb_start <= cfg_vblank_start;
            sh_vs_start <= cfg_vsync_start;
            sh_vs_end   <= cfg_vsync_end;
            sh_fs_delay <= cfg_fs_delay;
        end
    end

    spu_raster #(.HW(HW), .VW(VW), .PCW(PCW)) u_raster (
        .clk      (clk),
        .rst      (rst),
        .htotal   (sh_htotal),
        .hactive  (sh_hactive),
        .hs_start (sh_hs_start),
        .hs_end   (sh_hs_end),
        .vtotal   (sh_vtotal),
        .vb_start (sh_vb_start),
        .vs_start (sh_vs_start),
        .vs_end   (sh_vs_end),
        .fs_delay (sh_fs_delay),
        .line_q   (line_q),
        .hs_edge  (hs_edge),
        .evt_now  (evt_now),
        .evt_q    (evt_q),
        .pix_q    (pix_q),
        .de_o     (de_o),
        .hblank_o (hblank_o),
        .hsync_o  (hsync_o),
        .vblank_o (vblank_o),
        .vsync_o  (vsync_o)
    );

    spu_stamp #(.VW(VW), .FCW(FCW), .TSW(TSW)) u_stamp (
        .clk       (clk),
        .rst       (rst),
        .hs_edge   (hs_edge),
        .line_q    (line_q),
        .vbl_start (evt_now.vbl_start),
        .scan_q    (scan_q),
        .frame_q   (frame_q),
        .tsn_q     (tsn_q),
        .tsf_q     (tsf_q)
    );

    spu_regs #(.DW(DW), .VW(VW), .PCW(PCW), .FCW(FCW), .TSW(TSW)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .scan    (scan_q),
        .pix     (pix_q),
        .frame   (frame_q),
        .tsn     (tsn_q),
        .tsf     (tsf_q),
        .evt_now (evt_now),
        .rd_data (rd_data)
    );

    assign latch_o      = evt_q.vbl_start;
    assign evt_vblank_o = evt_q.vbl_start;
    assign evt_frame_o  = evt_q.frame_start;
    assign evt_vsync_o  = evt_q.vsync_start;

    // R5: the scanline counter moves only on an hsync leading edge
    p_scan_on_hsync_r5: assert property (@(posedge clk) disable iff (rst)
        (scan_q != $past(scan_q)) |-> (hsync_o && !$past(hsync_o)));

    // R7: the frame counter moves only with start of vblank
    p_frame_step_r7: assert property (@(posedge clk) disable iff (rst)
        (frame_q != $past(frame_q)) |-> evt_vblank_o);

    // R8: the frame timestamp is captured only at the latch strobe
    p_tsf_latch_r8: assert property (@(posedge clk) disable iff (rst)
        (tsf_q != $past(tsf_q)) |-> latch_o);

endmodule

// File: tb/scan_position_unit_test.sv
module scan_position_unit_test;
    localparam int HW = 8, VW = 8, DW = 8, PCW = 16, FCW = 6, TSW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [HW-1:0] cfg_htotal, cfg_hactive, cfg_hsync_start, cfg_hsync_end;
    logic [VW-1:0] cfg_vtotal, cfg_vblank_start, cfg_vsync_start, cfg_vsync_end;
    logic [1:0]    cfg_fs_delay;
    logic          de_o, hblank_o, hsync_o, vblank_o, vsync_o, latch_o;
    logic          evt_vblank_o, evt_frame_o, evt_vsync_o;
    logic          rd_en = 1'b0;
    logic [3:0]    rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          wr_en = 1'b0;
    logic [3:0]    wr_addr = '0;
    logic [2:0]    wr_data = '0;

    always #10 clk = ~clk;

    scan_position_unit #(.HW(HW), .VW(VW), .DW(DW), .PCW(PCW), .FCW(FCW), .TSW(TSW)) uut (
        .clk(clk), .rst(rst),
        .cfg_htotal(cfg_htotal), .cfg_hactive(cfg_hactive),
        .cfg_hsync_start(cfg_hsync_start), .cfg_hsync_end(cfg_hsync_end),
        .cfg_vtotal(cfg_vtotal), .cfg_vblank_start(cfg_vblank_start),
        .cfg_vsync_start(cfg_vsync_start), .cfg_vsync_end(cfg_vsync_end),
        .cfg_fs_delay(cfg_fs_delay),
        .de_o(de_o), .hblank_o(hblank_o), .hsync_o(hsync_o),
        .vblank_o(vblank_o), .vsync_o(vsync_o), .latch_o(latch_o),
        .evt_vblank_o(evt_vblank_o), .evt_frame_o(evt_frame_o), .evt_vsync_o(evt_vsync_o),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    string phase  = "R13_reset";

    // ---------------- behavioural reference ----------------
    int h, v, pix, sl, frm, tsn, tsf;
    int sht, sha, shs, she, svt, svb, svs, sve, sfd;
    int stat, rdd;
    int snap [4];
    int vals [4];
    int e_de, e_hb, e_hs, e_vb, e_vs, e_evb, e_efs, e_evs;
    string rd_tag = "R9";

    task automatic load_shadow();
        sht = cfg_htotal;  sha = cfg_hactive; shs = cfg_hsync_start; she = cfg_hsync_end;
        svt = cfg_vtotal;  svb = cfg_vblank_start; svs = cfg_vsync_start; sve = cfg_vsync_end;
        sfd = cfg_fs_delay;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            h = 0; v = 0; pix = 0; sl = 0; frm = 0; tsn = 0; tsf = 0;
            stat = 0; rdd = 0;
            for (int k = 0; k < 4; k++) snap[k] = 0;
            e_de = 0; e_hb = 0; e_hs = 0; e_vb = 0; e_vs = 0; e_evb = 0; e_efs = 0; e_evs = 0;
            load_shadow();
        end else begin
            int at_hs, evb, evs, eve, ebe, efs, clr, a;
            at_hs = (h == shs);
            evb = at_hs && (v == svb - 1);
            evs = at_hs && (v == svs - 1);
            eve = at_hs && (v == sve - 1);
            ebe = at_hs && (v == svt - 1);
            efs = (h == sha) && (v == svb + sfd);
            e_de = (h < sha) && (v < svb);
            e_hb = (h >= sha);
            e_hs = (h >= shs) && (h < she);
            if (evb) e_vb = 1; else if (ebe) e_vb = 0;
            if (evs) e_vs = 1; else if (eve) e_vs = 0;
            e_evb = evb; e_efs = efs; e_evs = evs;
            vals[0] = pix; vals[1] = frm; vals[2] = tsn; vals[3] = tsf;
            if (rd_en) begin
                a = rd_addr;
                if (a == 0) begin rdd = sl & 255; rd_tag = "R5"; end
                else if (a >= 1 && a <= 8) begin
                    int k;
                    k = (a - 1) / 2;
                    if (((a - 1) % 2) == 0) begin
                        rdd = vals[k] & 255;
                        snap[k] = (vals[k] >> 8) & 255;
                        rd_tag = (k == 0) ? "R6" : (k == 1) ? "R7" : "R8";
                    end else begin
                        rdd = snap[k];
                        rd_tag = "R10";
                    end
                end
                else if (a == 9) begin rdd = stat; rd_tag = "R11"; end
                else begin rdd = 0; rd_tag = "R9"; end
            end
            clr = (wr_en && wr_addr == 9) ? wr_data : 0;
            stat = (stat & ~clr & 7) | (evs << 2) | (efs << 1) | evb;
            if (at_hs) sl = v;
            if (evb) tsf = tsn;
            frm = (frm + evb) % (1 << FCW);
            tsn = (tsn + 1) % (1 << TSW);
            pix = (h >= sht - 1 && v >= svt - 1) ? 0 : (pix + 1) % (1 << PCW);
            if (h >= sht - 1) begin
                h = 0;
                v = (v >= svt - 1) ? 0 : v + 1;
            end else h = h + 1;
            if (evb) load_shadow();
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s [%s]: actual %0h expected %0h", tag, what, phase, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            chk("R1", "de_o", int'(de_o), e_de);
            chk("R1", "hblank_o", int'(hblank_o), e_hb);
            chk("R1", "hsync_o", int'(hsync_o), e_hs);
            chk("R2", "vblank_o", int'(vblank_o), e_vb);
            chk("R2", "latch_o", int'(latch_o), e_evb);
            chk("R2", "evt_vblank_o", int'(evt_vblank_o), e_evb);
            chk("R3", "vsync_o", int'(vsync_o), e_vs);
            chk("R3", "evt_vsync_o", int'(evt_vsync_o), e_evs);
            chk("R4", "evt_frame_o", int'(evt_frame_o), e_efs);
            chk(rd_tag, "rd_data", int'(rd_data), rdd);
        end
    end

    // ---------------- stimulus ----------------
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input int a);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 4'(a);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = 3'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_cfg(input int ht, input int ha, input int hs, input int he,
                           input int vt, input int vb, input int vs, input int ve, input int fd);
        cfg_htotal = HW'(ht); cfg_hactive = HW'(ha); cfg_hsync_start = HW'(hs); cfg_hsync_end = HW'(he);
        cfg_vtotal = VW'(vt); cfg_vblank_start = VW'(vb); cfg_vsync_start = VW'(vs);
        cfg_vsync_end = VW'(ve); cfg_fs_delay = 2'(fd);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        set_cfg(10, 6, 7, 9, 10, 5, 6, 8, 1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R13: everything is zero while reset is held
        chk("R13", "de_o in reset", int'(de_o), 0);
        chk("R13", "vblank_o in reset", int'(vblank_o), 0);
        chk("R13", "evt pulses in reset", int'(evt_vblank_o | evt_frame_o | evt_vsync_o), 0);
        chk("R13", "rd_data in reset", int'(rd_data), 0);
        rst = 1'b0;
        rd(0);
        chk("R13", "scanline after reset", int'(rd_data), 0);

        phase = "R9_reads";
        for (int i = 0; i < 80; i++) begin
            rd(i % 11);
            idle(i % 3);
        end
        rd(12);
        rd(15);

        phase = "R10_snapshot";
        for (int k = 0; k < 4; k++) begin
            rd(1 + 2 * k);
            idle(300);
            rd(5);
            rd(2 + 2 * k);
        end

        phase = "R11_status";
        rd(9);
        wr(3, 7);
        rd(9);
        wr(9, 7);
        rd(9);
        for (int i = 0; i < 120; i++) begin
            wr(9, i % 8);
            rd(9);
        end

        phase = "R4_delay";
        for (int d = 0; d < 4; d++) begin
            set_cfg(10, 6, 7, 9, 10, 5, 6, 8, d);
            for (int i = 0; i < 100; i++) begin
                rd(9);
                wr(9, 7);
            end
        end

        phase = "R12_cfg_hold";
        idle(23);
        set_cfg(12, 8, 9, 11, 10, 6, 7, 9, 2);
        for (int i = 0; i < 180; i++) begin
            rd(i % 2 == 0 ? 0 : 1);
        end

        phase = "R7_wrap";
        idle(31);
        set_cfg(4, 2, 2, 3, 3, 2, 2, 3, 0);
        for (int i = 0; i < 500; i++) begin
            rd((i % 4 == 0) ? 3 : (i % 4 == 1) ? 7 : (i % 4 == 2) ? 0 : 1);
        end

        phase = "R8_timestamps";
        for (int i = 0; i < 40; i++) begin
            rd(7);
            rd(8);
            rd(5);
            rd(6);
        end

        idle(4);
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL R9 watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule